// File: doc/BRIEF.md
# GPIO Pad Group Controller

The block holds a parameterised group of general-purpose pads behind a simple 32-bit register bus. Every pad owns two 32-bit configuration words placed in a linear array. The array starts at a byte offset that software learns from a fixed read-only pointer register, and successive pads sit a fixed stride apart. The first word of a pad sets the value driven on the pad output. It also reports the synchronised pad input, and it selects how that input is turned into interrupt events: the polarity, the kind of event, and a two-bit reset-domain tag that the block stores without acting on it. The second word is a plain 32-bit storage register for software.

Pads are grouped into banks of up to 32. Each bank has an event status register, cleared by writing 1, and an enable register. Status bits latch whether or not they are enabled. The single interrupt output is high while any bank has a bit that is both latched and enabled. Software acknowledges events by writing back the status value it has just read.

There is no state machine in the block. Its behaviour is set by the per-pad event selector, which has four modes: level, rising edge, both edges, and off.

Top module: `gpc_community`

## Requirements
- R1: Offset 0x00C reads back the byte offset of the pad array, PAD_BASE (default 0x400). Writes to it are ignored.
- R2: Pad p's first word is at PAD_BASE + p*PAD_STRIDE and its second word is at 4 bytes above that. The second word stores and returns all 32 bits. Bits of the first word that are not defined in R3 to R6 read 0.
- R3: First-word bit 0 drives pad_out[p]. First-word bit 1 reads the pad input after a two-flop synchroniser, and writes to bit 1 have no effect.
- R4: First-word bit 23 inverts the synchronised input before event detection. Changing this bit alone produces no edge event.
- R5: First-word bits 26:25 select the event mode. 00 is level: the status bit is set on every cycle the processed input is high, so it re-asserts after a clear. 01 is the rising edge of the processed input. 11 is either edge. 10 produces no events.
- R6: First-word bits 31:30 are stored and read back unchanged.
- R7: Bank n has its status register at 0x100+4n and its enable register at 0x120+4n, with bit k belonging to pad 32n+k. Bits with no pad read 0. Status bits latch regardless of enable.
- R8: Writing 1 to a status bit clears it and writing 0 has no effect. An event in the same cycle as the clear wins.
- R9: irq is high exactly when some bank has a bit set in both status and enable.
- R10: Reads of undefined offsets return 0, including pad-word slots beyond the second word and addresses past the last pad. Writes to undefined offsets are ignored.
- R11: A read returns data on bus_rdata after the clock edge that sampled it, and the value holds until the next read. An input level first present before clock edge k reaches the status register at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PADS | Asynchronous pad inputs |
| pad_out | output | NUM_PADS | Pad output values |
| irq | output | 1 | Combined interrupt |

## Verification
The event path is driven with pulses and steps on single pads under each of the four modes, with and without inversion. These patterns tell apart level, rising-only, either-edge and disabled detection. A clear issued while a level is still present distinguishes re-assertion from edge latching. Flipping inversion on a steady input shows that a polarity change is not taken as an edge. Pads in the partial second bank expose mistakes in bank indexing and bit masking, and a timed step on an enabled pad pins the two-stage synchroniser latency at the interrupt output.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
    typedef enum logic [1:0] {
        EV_LEVEL = 2'b00,
        EV_RISE  = 2'b01,
        EV_OFF   = 2'b10,
        EV_BOTH  = 2'b11
    } ev_mode_e;

    localparam int OFS_PTR  = 'h00C;
    localparam int OFS_STAT = 'h100;
    localparam int OFS_EN   = 'h120;

    localparam int BIT_TX   = 0;
    localparam int BIT_INV  = 23;
    localparam int BIT_EVLO = 25;
    localparam int BIT_RCLO = 30;
endpackage

// File: rtl/gpc_sync.sv
module gpc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q, stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/gpc_pad.sv
module gpc_pad
    import gpc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_w0_i,
    input  logic        wr_w1_i,
    input  logic [31:0] wdata_i,
    input  logic        rx_i,
    output logic [31:0] w0_o,
    output logic [31:0] w1_o,
    output logic        tx_o,
    output logic        evt_o
);
    logic       tx_q, inv_q, prev_q;
    ev_mode_e   mode_q;
    logic [1:0] rcfg_q;
    logic [31:0] w1_q;
    logic       cur, old;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= 1'b0;
            inv_q  <= 1'b0;
            mode_q <= EV_LEVEL;
            rcfg_q <= 2'b00;
            w1_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= rx_i;
            if (wr_w0_i) begin
                tx_q   <= wdata_i[BIT_TX];
                inv_q  <= wdata_i[BIT_INV];
                mode_q <= ev_mode_e'(wdata_i[BIT_EVLO +: 2]);
                rcfg_q <= wdata_i[BIT_RCLO +: 2];
            end
            if (wr_w1_i) begin
                w1_q <= wdata_i;
            end
        end
    end

    // previous sample is judged with the current polarity, so a polarity
    // change alone never looks like an edge (R4)
    always_comb begin
        cur = rx_i ^ inv_q;
        old = prev_q ^ inv_q;
        unique case (mode_q)
            EV_LEVEL: evt_o = cur;
            EV_RISE:  evt_o = cur & ~old;
            EV_BOTH:  evt_o = cur ^ old;
            EV_OFF:   evt_o = 1'b0;
        endcase
    end

    assign w0_o = {rcfg_q, 3'b000, mode_q, 1'b0, inv_q, 21'd0, rx_i, tx_q};
    assign w1_o = w1_q;
    assign tx_o = tx_q;

    a_r6_rcfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_w0_i |=> $stable(rcfg_q));

    a_r5_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != EV_LEVEL && evt_o) |-> (rx_i != prev_q));
endmodule

// File: rtl/gpc_bank.sv
module gpc_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             clr_we_i,
    input  logic             en_we_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] status_o,
    output logic [WIDTH-1:0] enable_o,
    output logic             hit_o
);
    logic [WIDTH-1:0] status_q, enable_q, clr_mask;

    assign clr_mask = clr_we_i ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | set_i;
            if (en_we_i) begin
                enable_q <= wdata_i;
            end
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
    assign hit_o    = |(status_q & enable_q);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(set_i)) == $past(set_i)));

    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((status_o & $past(wdata_i & ~set_i)) == '0));
endmodule

// File: rtl/gpc_community.sv
module gpc_community
    import gpc_pkg::*;
#(
    parameter int NUM_PADS   = 40,
    parameter int PAD_STRIDE = 16,
    parameter int PAD_BASE   = 'h400,
    parameter int ADDR_W     = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic                irq
);
    localparam int NUM_BANKS = (NUM_PADS + 31) / 32;
    localparam int STRIDE_SH = $clog2(PAD_STRIDE);
    localparam int PAD_END   = PAD_BASE + NUM_PADS * PAD_STRIDE;

    logic                wr;
    int                  addr_i, pad_idx, word;
    logic                in_pad;
    logic [NUM_PADS-1:0] rx_s, evt_v, wr0_v, wr1_v;
    logic [31:0]         w0_a [NUM_PADS];
    logic [31:0]         w1_a [NUM_PADS];
    logic [31:0]         stat_w [NUM_BANKS];
    logic [31:0]         en_w [NUM_BANKS];
    logic [NUM_BANKS-1:0] hit_v, en_nz;
    logic [31:0]         rd_val, rdata_q;

    assign wr = bus_sel & bus_wr;

    always_comb begin
        addr_i = 0;
        addr_i[ADDR_W-1:0] = bus_addr;
        in_pad  = (addr_i >= PAD_BASE) && (addr_i < PAD_END);
        pad_idx = (addr_i - PAD_BASE) >>> STRIDE_SH;
        word    = (addr_i - PAD_BASE) & (PAD_STRIDE - 1);
        for (int p = 0; p < NUM_PADS; p++) begin
            wr0_v[p] = wr && in_pad && (pad_idx == p) && (word == 0);
            wr1_v[p] = wr && in_pad && (pad_idx == p) && (word == 4);
        end
    end

    gpc_sync #(.W(NUM_PADS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_in),
        .q_o   (rx_s)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        gpc_pad i_pad (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_w0_i (wr0_v[p]),
            .wr_w1_i (wr1_v[p]),
            .wdata_i (bus_wdata),
            .rx_i    (rx_s[p]),
            .w0_o    (w0_a[p]),
            .w1_o    (w1_a[p]),
            .tx_o    (pad_out[p]),
            .evt_o   (evt_v[p])
        );
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BW = (b == NUM_BANKS - 1) ? (NUM_PADS - 32 * b) : 32;
        logic [BW-1:0] st_b, en_b;
        logic          clr_we, en_we;

        assign clr_we = wr && (bus_addr == ADDR_W'(OFS_STAT + 4 * b));
        assign en_we  = wr && (bus_addr == ADDR_W'(OFS_EN + 4 * b));

        gpc_bank #(.WIDTH(BW)) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (evt_v[32 * b +: BW]),
            .clr_we_i (clr_we),
            .en_we_i  (en_we),
            .wdata_i  (bus_wdata[BW-1:0]),
            .status_o (st_b),
            .enable_o (en_b),
            .hit_o    (hit_v[b])
        );

        assign stat_w[b] = 32'(st_b);
        assign en_w[b]   = 32'(en_b);
        assign en_nz[b]  = |en_b;
    end

    always_comb begin
        rd_val = '0;
        if (bus_addr == ADDR_W'(OFS_PTR)) begin
            rd_val = 32'(PAD_BASE);
        end
        for (int p = 0; p < NUM_PADS; p++) begin
            if (in_pad && pad_idx == p) begin
                if (word == 0)      rd_val = w0_a[p];
                else if (word == 4) rd_val = w1_a[p];
            end
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(OFS_STAT + 4 * b)) rd_val = stat_w[b];
            if (bus_addr == ADDR_W'(OFS_EN + 4 * b))   rd_val = en_w[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_sel && !bus_wr) begin
            rdata_q <= rd_val;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = |hit_v;

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|en_nz));

    a_r1_pointer_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_PTR)) |=> (bus_rdata == 32'(PAD_BASE)));

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

// File: tb/test_gpc_community.sv
`timescale 1ns/1ps
module test_gpc_community;
    localparam int NP = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NP-1:0] pin = '0;
    logic [NP-1:0] pout;
    logic        irq;

    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    gpc_community i_gpc_community (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pin), .pad_out(pout), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    bit        s1 [NP], s2 [NP], pv [NP], tx [NP], inv [NP];
    bit [1:0]  md [NP], rc [NP];
    bit [31:0] d1 [NP];
    bit [31:0] st [2], en [2];
    bit [31:0] rd_m;
    int        last_rd;

    function automatic bit [31:0] bank_mask(int b);
        return (b == 1) ? 32'h0000_00FF : 32'hFFFF_FFFF;
    endfunction

    function automatic bit [31:0] mread(int a);
        int p, w;
        if (a == 'h00C) return 32'h400;
        if (a >= 'h400 && a < 'h680) begin
            p = (a - 'h400) / 16;
            w = (a - 'h400) % 16;
            if (w == 0) return {rc[p], 3'b0, md[p], 1'b0, inv[p], 21'd0, s2[p], tx[p]};
            if (w == 4) return d1[p];
            return 0;
        end
        if (a == 'h100) return st[0];
        if (a == 'h104) return st[1];
        if (a == 'h120) return en[0];
        if (a == 'h124) return en[1];
        return 0;
    endfunction

    always @(posedge clk) begin
        bit [31:0] setv [2];
        bit cur, old, e;
        int a, p;
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                s1[i] = 0; s2[i] = 0; pv[i] = 0; tx[i] = 0; inv[i] = 0;
                md[i] = 0; rc[i] = 0; d1[i] = 0;
            end
            st[0] = 0; st[1] = 0; en[0] = 0; en[1] = 0; rd_m = 0; last_rd = 0;
        end else begin
            setv[0] = 0; setv[1] = 0;
            for (int i = 0; i < NP; i++) begin
                cur = s2[i] ^ inv[i];
                old = pv[i] ^ inv[i];
                case (md[i])
                    2'b00: e = cur;
                    2'b01: e = cur && !old;
                    2'b11: e = cur != old;
                    default: e = 0;
                endcase
                if (e) setv[i / 32][i % 32] = 1'b1;
            end
            a = int'(addr);
            if (sel && !wr) begin
                rd_m = mread(a);
                last_rd = a;
            end
            for (int b = 0; b < 2; b++) begin
                if (sel && wr && a == 'h100 + 4 * b) st[b] = st[b] & ~wdata;
                st[b] = (st[b] | setv[b]) & bank_mask(b);
                if (sel && wr && a == 'h120 + 4 * b) en[b] = wdata & bank_mask(b);
            end
            if (sel && wr && a >= 'h400 && a < 'h680) begin
                p = (a - 'h400) / 16;
                if ((a - 'h400) % 16 == 0) begin
                    tx[p] = wdata[0]; inv[p] = wdata[23];
                    md[p] = wdata[26:25]; rc[p] = wdata[31:30];
                end
                if ((a - 'h400) % 16 == 4) d1[p] = wdata;
            end
            for (int i = 0; i < NP; i++) begin
                pv[i] = s2[i]; s2[i] = s1[i]; s1[i] = pin[i];
            end
        end
    end

    function automatic string tag_of(int a);
        if (a == 'h00C) return "R1";
        if (a >= 'h400 && a < 'h680) return "R2";
        if (a >= 'h100 && a < 'h128) return "R7";
        return "R10";
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic [NP-1:0] txv;
        if (rst_n) begin
            for (int i = 0; i < NP; i++) txv[i] = tx[i];
            check(irq == |((st[0] & en[0]) | (st[1] & en[1])), "R9 irq model", 64'(irq),
                  64'(|((st[0] & en[0]) | (st[1] & en[1]))));
            check(pout == txv, "R3 pad_out model", 64'(pout), 64'(txv));
            check(rdata == rd_m, {tag_of(last_rd), " rdata model"}, 64'(rdata), 64'(rd_m));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bw(int a, logic [31:0] d);
        @(negedge clk); sel = 1; wr = 1; addr = 12'(a); wdata = d;
        @(negedge clk); sel = 0; wr = 0;
    endtask

    task automatic brd(int a, logic [31:0] exp, string tag);
        @(negedge clk); sel = 1; wr = 0; addr = 12'(a);
        @(negedge clk); sel = 0;
        check(rdata == exp, tag, 64'(rdata), 64'(exp));
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(irq == 0, "R9 reset irq", 64'(irq), 0);
        check(pout == 0, "R3 reset pad_out", 64'(pout), 0);
        check(rdata == 0, "R11 reset rdata", 64'(rdata), 0);

        // R11 latency: enable pad 8, step its input
        bw('h120, 32'h100);
        @(negedge clk); pin[8] = 1;
        @(negedge clk); check(irq == 0, "R11 after edge k", 64'(irq), 0);
        @(negedge clk); check(irq == 0, "R11 after edge k+1", 64'(irq), 0);
        @(negedge clk); check(irq == 1, "R11 after edge k+2", 64'(irq), 1);
        pin[8] = 0;
        cyc(4);
        bw('h100, 32'h100);
        brd('h100, 32'h0, "R8 clear pad8");
        bw('h120, 32'h0);

        // R1 pointer
        brd('h00C, 32'h400, "R1 pointer");
        bw('h00C, 32'h0);
        brd('h00C, 32'h400, "R1 pointer write ignored");

        // R2 second word / R6 reset tag / bit layout
        bw('h434, 32'hDEADBEEF);
        brd('h434, 32'hDEADBEEF, "R2 second word");
        brd('h430, 32'h0, "R2 first word reset");
        bw('h400, 32'hFFFF_FFFF);
        brd('h400, 32'hC680_0001, "R2 R6 first word fields");
        check(pout[0] == 1, "R3 tx drives pad_out", 64'(pout[0]), 1);
        bw('h400, 32'h0);
        bw('h480, 32'h8000_0000);
        brd('h480, 32'h8000_0000, "R6 reset tag");

        // R3 rx, R5 level re-assert, R7 latch without enable, R8
        pin[5] = 1;
        cyc(4);
        brd('h450, 32'h2, "R3 rx bit");
        brd('h100, 32'h20, "R7 latched without enable");
        check(irq == 0, "R7 irq off while disabled", 64'(irq), 0);
        bw('h100, 32'h20);
        brd('h100, 32'h20, "R5 level re-asserts");
        pin[5] = 0;
        cyc(4);
        bw('h100, 32'h0);
        brd('h100, 32'h20, "R8 zero write no effect");
        bw('h100, 32'h20);
        brd('h100, 32'h0, "R8 w1c");

        // R5 rising on pad 33 (bank 1 bit 1)
        bw('h610, 32'h0200_0000);
        pin[33] = 1;
        cyc(4);
        brd('h104, 32'h2, "R5 rising");
        bw('h104, 32'h2);
        brd('h104, 32'h0, "R5 edge no re-assert");
        pin[33] = 0;
        cyc(4);
        brd('h104, 32'h0, "R5 falling ignored in rising mode");
        bw('h124, 32'h2);
        pin[33] = 1;
        cyc(4);
        check(irq == 1, "R9 irq on enabled event", 64'(irq), 1);
        bw('h124, 32'h0);
        check(irq == 0, "R9 irq drops with enable", 64'(irq), 0);
        bw('h104, 32'h2);

        // R4 R5 both edges with inversion on pad 34
        bw('h620, 32'h0680_0000);
        cyc(3);
        brd('h104, 32'h0, "R4 polarity change no edge");
        pin[34] = 1;
        cyc(4);
        brd('h104, 32'h4, "R5 both edges falling");
        bw('h104, 32'h4);
        pin[34] = 0;
        cyc(4);
        brd('h104, 32'h4, "R5 both edges rising");
        bw('h104, 32'h4);

        // R4 inverted level on pad 6
        bw('h460, 32'h0080_0000);
        cyc(3);
        brd('h100, 32'h40, "R4 inverted level");
        bw('h460, 32'h0);
        bw('h100, 32'h40);
        brd('h100, 32'h0, "R4 clear after restore");

        // R5 mode 10 on pad 7
        bw('h470, 32'h0400_0000);
        pin[7] = 1; cyc(4);
        pin[7] = 0; cyc(4);
        brd('h100, 32'h0, "R5 mode off");

        // R7 partial bank, R10 undefined
        bw('h124, 32'hFFFF_FFFF);
        brd('h124, 32'hFF, "R7 partial bank mask");
        bw('h124, 32'h0);
        bw('h200, 32'hFFFF_FFFF);
        brd('h200, 32'h0, "R10 undefined offset");
        bw('h408, 32'hFFFF_FFFF);
        brd('h408, 32'h0, "R10 gap in stride");
        brd('h680, 32'h0, "R10 past last pad");

        cyc(4);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule